// File: doc/BRIEF.md
# Per-Gate Pending Event Filter

This block holds the short, time-ordered list of output-change events that are waiting to mature on a single simulated gate. When gate evaluation proposes a new event, given as a time and a value, the block decides in one cycle whether the event is worth keeping. It also cancels pending events that the new one has made redundant. It rejects narrow pulses under an inertial-delay rule, so that an event which would undo the previous change too soon is dropped together with that change.

A pop request, carrying the current simulation time, retires the earliest event when its time matches. The retired value becomes the gate's committed output, and a one-cycle change strobe is raised. Values are 2-bit codes: zero is 2'b00, one is 2'b01 and unknown is 2'b10. Times are unsigned integers. Within the list, events with equal times are placed in arrival order.

The block has no multi-cycle control flow. Each cycle is a fixed pipeline: a pop stage runs first, then a locate stage, then a decision stage that picks one of six actions. Those actions are NONE, INSERT, REPLACE, DISCARD, DROP_LAST and OVERFLOW.

Top module: `pend_event_filter`

## Requirements
- R1: After reset the list is empty (count 0, head_valid 0), the committed output is unknown (2'b10) and the overflow flag is 0.
- R2: With an empty list, a proposed event is accepted only if its value differs from the committed output; otherwise it is discarded.
- R3: An event whose time is at or after the last pending time is accepted only if its value differs from the last pending value. The list stays sorted by time.
- R4: An event whose time is earlier than every pending time is always accepted. If the first pending event carries the same value, that event is overwritten by the new one, so the count is unchanged.
- R5: An event that lands between two pending events is discarded if its value equals the preceding event's value. Once it is accepted, a following event that carries the same value is removed.
- R6: If an otherwise acceptable appended event comes less than inertial_dly time units after the last pending event and restores the value that preceded it, the new event is discarded and the last pending event is deleted.
- R7: The capacity is DEPTH entries (4). A proposal that would add a fifth entry is discarded and sets a sticky overflow flag, which only reset clears.
- R8: A pop with cur_time equal to the head time removes the head, loads its value into out_val, and pulses out_change for one cycle. A pop with any other time has no effect.
- R9: When a propose and a pop occur in the same cycle, the pop is applied first, and the propose is judged against the resulting list and committed output.
- R10: Exactly one of prop_accept and prop_discard pulses in the cycle after each propose. The head outputs always show the earliest pending event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prop_valid | input | 1 | Propose strobe |
| prop_time | input | TW | Time of proposed event |
| prop_val | input | 2 | Value code of proposed event |
| inertial_dly | input | TW | Minimum pulse width kept |
| pop_req | input | 1 | Pop request |
| cur_time | input | TW | Current simulation time for pop |
| prop_accept | output | 1 | Proposal kept (one cycle) |
| prop_discard | output | 1 | Proposal dropped (one cycle) |
| head_valid | output | 1 | List not empty |
| head_time | output | TW | Earliest pending time |
| head_val | output | 2 | Earliest pending value |
| pend_count | output | CW | Number of pending events |
| out_val | output | 2 | Committed output value |
| out_change | output | 1 | Head matured this cycle |
| overflow | output | 1 | Sticky capacity overflow |

## Verification
The bench builds the block with its defaults: DEPTH of 4 and TW of 32. A depth of four can be filled with a handful of proposals, so the overflow path and a full list accepting a REPLACE are both reachable. The 32-bit times allow the inertial scenario to be reproduced with small literal times. The inertial delay is a port, so the bench switches it between 0 and 3 at run time. That exercises the pulse-rejection branch on both sides of its threshold within one build.

// File: rtl/pef_pkg.sv
package pef_pkg;
    typedef logic [1:0] val_t;

    localparam val_t VAL_ZERO = 2'b00;
    localparam val_t VAL_ONE  = 2'b01;
    localparam val_t VAL_UNK  = 2'b10;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_INSERT,
        ACT_REPLACE,
        ACT_DISCARD,
        ACT_DROP_LAST,
        ACT_OVERFLOW
    } act_e;
endpackage

// File: rtl/pef_pop_stage.sv
module pef_pop_stage
    import pef_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TW    = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][TW-1:0] tim_q,
    input  logic [DEPTH-1:0][1:0]    val_q,
    input  logic [CW-1:0]            cnt_q,
    input  val_t                     cmt_q,
    input  logic                     pop_req,
    input  logic [TW-1:0]            cur_time,
    output logic [DEPTH-1:0][TW-1:0] tim_a,
    output logic [DEPTH-1:0][1:0]    val_a,
    output logic [CW-1:0]            cnt_a,
    output val_t                     cmt_a,
    output logic                     pop_fire
);
    assign pop_fire = pop_req && (cnt_q != '0) && (cur_time == tim_q[0]);
    assign cnt_a    = pop_fire ? cnt_q - CW'(1) : cnt_q;
    assign cmt_a    = pop_fire ? val_q[0] : cmt_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_shift
        if (i < DEPTH - 1) begin : g_mid
            assign tim_a[i] = pop_fire ? tim_q[i+1] : tim_q[i];
            assign val_a[i] = pop_fire ? val_q[i+1] : val_q[i];
        end else begin : g_top
            assign tim_a[i] = pop_fire ? '0 : tim_q[i];
            assign val_a[i] = pop_fire ? '0 : val_q[i];
        end
    end
endmodule

// File: rtl/pef_locate.sv
module pef_locate
    import pef_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TW    = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][TW-1:0] tim_a,
    input  logic [DEPTH-1:0][1:0]    val_a,
    input  logic [CW-1:0]            cnt_a,
    input  val_t                     cmt_a,
    input  logic [TW-1:0]            new_time,
    output logic [CW-1:0]            pos,
    output val_t                     pred_val,
    output logic [TW-1:0]            pred_time,
    output val_t                     succ_val,
    output val_t                     prev2_val
);
    always_comb begin
        pos = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if ((CW'(i) < cnt_a) && (tim_a[i] <= new_time)) begin
                pos = pos + CW'(1);
            end
        end
    end

    always_comb begin
        pred_val  = cmt_a;
        pred_time = '0;
        succ_val  = VAL_UNK;
        prev2_val = cmt_a;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i + 1) == pos) begin
                pred_val  = val_a[i];
                pred_time = tim_a[i];
            end
            if (CW'(i) == pos) begin
                succ_val = val_a[i];
            end
            if (CW'(i + 2) == pos) begin
                prev2_val = val_a[i];
            end
        end
    end
endmodule

// File: rtl/pef_decide.sv
module pef_decide
    import pef_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TW    = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          prop_valid,
    input  logic [CW-1:0] cnt_a,
    input  logic [CW-1:0] pos,
    input  val_t          pred_val,
    input  logic [TW-1:0] pred_time,
    input  val_t          succ_val,
    input  val_t          prev2_val,
    input  logic [TW-1:0] new_time,
    input  val_t          new_val,
    input  logic [TW-1:0] inertial_dly,
    output act_e          act
);
    logic          full;
    logic [TW-1:0] gap;
    act_e          base;

    assign full = (cnt_a == CW'(DEPTH));
    assign gap  = new_time - pred_time;

    always_comb begin
        base = ACT_DISCARD;
        if (cnt_a == '0) begin
            base = (new_val != pred_val) ? ACT_INSERT : ACT_DISCARD;
        end else if (pos == cnt_a) begin
            if (new_val == pred_val) begin
                base = ACT_DISCARD;
            end else if ((gap < inertial_dly) && (new_val == prev2_val)) begin
                base = ACT_DROP_LAST;
            end else begin
                base = ACT_INSERT;
            end
        end else if (pos == '0) begin
            base = (succ_val == new_val) ? ACT_REPLACE : ACT_INSERT;
        end else if (new_val == pred_val) begin
            base = ACT_DISCARD;
        end else begin
            base = (succ_val == new_val) ? ACT_REPLACE : ACT_INSERT;
        end
    end

    always_comb begin
        if (!prop_valid) begin
            act = ACT_NONE;
        end else if ((base == ACT_INSERT) && full) begin
            act = ACT_OVERFLOW;
        end else begin
            act = base;
        end
    end
endmodule

// File: rtl/pend_event_filter.sv
module pend_event_filter
    import pef_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TW    = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prop_valid,
    input  logic [TW-1:0] prop_time,
    input  logic [1:0]    prop_val,
    input  logic [TW-1:0] inertial_dly,
    input  logic          pop_req,
    input  logic [TW-1:0] cur_time,
    output logic          prop_accept,
    output logic          prop_discard,
    output logic          head_valid,
    output logic [TW-1:0] head_time,
    output logic [1:0]    head_val,
    output logic [CW-1:0] pend_count,
    output logic [1:0]    out_val,
    output logic          out_change,
    output logic          overflow
);
    logic [DEPTH-1:0][TW-1:0] tim_q, tim_a, tim_n;
    logic [DEPTH-1:0][1:0]    val_q, val_a, val_n;
    logic [CW-1:0]            cnt_q, cnt_a, cnt_n;
    val_t                     cmt_q, cmt_a;
    logic                     ovf_q, acc_q, dis_q, chg_q;
    logic                     pop_fire;
    logic [CW-1:0]            pos;
    val_t                     pred_val, succ_val, prev2_val;
    logic [TW-1:0]            pred_time;
    act_e                     act;

    pef_pop_stage #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_pop (
        .tim_q(tim_q), .val_q(val_q), .cnt_q(cnt_q), .cmt_q(cmt_q),
        .pop_req(pop_req), .cur_time(cur_time),
        .tim_a(tim_a), .val_a(val_a), .cnt_a(cnt_a), .cmt_a(cmt_a),
        .pop_fire(pop_fire)
    );

    pef_locate #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_loc (
        .tim_a(tim_a), .val_a(val_a), .cnt_a(cnt_a), .cmt_a(cmt_a),
        .new_time(prop_time), .pos(pos), .pred_val(pred_val),
        .pred_time(pred_time), .succ_val(succ_val), .prev2_val(prev2_val)
    );

    pef_decide #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_dec (
        .prop_valid(prop_valid), .cnt_a(cnt_a), .pos(pos),
        .pred_val(pred_val), .pred_time(pred_time), .succ_val(succ_val),
        .prev2_val(prev2_val), .new_time(prop_time), .new_val(prop_val),
        .inertial_dly(inertial_dly), .act(act)
    );

    // Next list contents from the chosen action
    always_comb begin
        tim_n = tim_a;
        val_n = val_a;
        cnt_n = cnt_a;
        unique case (act)
            ACT_INSERT: begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i) == pos) begin
                        tim_n[i] = prop_time;
                        val_n[i] = prop_val;
                    end else if ((i > 0) && (CW'(i) > pos)) begin
                        tim_n[i] = tim_a[i-1];
                        val_n[i] = val_a[i-1];
                    end
                end
                cnt_n = cnt_a + CW'(1);
            end
            ACT_REPLACE: begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i) == pos) begin
                        tim_n[i] = prop_time;
                        val_n[i] = prop_val;
                    end
                end
            end
            ACT_DROP_LAST: cnt_n = cnt_a - CW'(1);
            ACT_NONE, ACT_DISCARD, ACT_OVERFLOW: ;
            default: ;
        endcase
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) >= cnt_n) begin
                tim_n[i] = '0;
                val_n[i] = '0;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_q <= '0;
            val_q <= '0;
            cnt_q <= '0;
            cmt_q <= VAL_UNK;
            ovf_q <= 1'b0;
        end else begin
            tim_q <= tim_n;
            val_q <= val_n;
            cnt_q <= cnt_n;
            cmt_q <= cmt_a;
            ovf_q <= ovf_q || (act == ACT_OVERFLOW);
        end
    end

    // Status strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
            dis_q <= 1'b0;
            chg_q <= 1'b0;
        end else begin
            acc_q <= (act == ACT_INSERT) || (act == ACT_REPLACE);
            dis_q <= (act == ACT_DISCARD) || (act == ACT_DROP_LAST) ||
                     (act == ACT_OVERFLOW);
            chg_q <= pop_fire;
        end
    end

    assign prop_accept  = acc_q;
    assign prop_discard = dis_q;
    assign head_valid   = (cnt_q != '0);
    assign head_time    = tim_q[0];
    assign head_val     = val_q[0];
    assign pend_count   = cnt_q;
    assign out_val      = cmt_q;
    assign out_change   = chg_q;
    assign overflow     = ovf_q;
endmodule

// File: rtl/pef_checker.sv
module pef_checker #(
    parameter int DEPTH = 4,
    parameter int TW    = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prop_valid,
    input logic          pop_req,
    input logic          prop_accept,
    input logic          prop_discard,
    input logic          head_valid,
    input logic [CW-1:0] pend_count,
    input logic          out_change,
    input logic          overflow,
    input logic [TW-1:0] t0,
    input logic [TW-1:0] t1
);
    p_excl_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(prop_accept && prop_discard));

    p_status_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_accept || prop_discard) |-> $past(prop_valid));

    p_propose_answered_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prop_valid |=> (prop_accept || prop_discard));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_count <= CW'(DEPTH));

    p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_change_from_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_change |-> ($past(pop_req) && $past(head_valid)));

    p_sorted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_count >= CW'(2)) |-> (t0 <= t1));
endmodule

bind pend_event_filter pef_checker #(.DEPTH(DEPTH), .TW(TW)) u_pef_chk (
    .clk(clk), .rst_n(rst_n), .prop_valid(prop_valid), .pop_req(pop_req),
    .prop_accept(prop_accept), .prop_discard(prop_discard),
    .head_valid(head_valid), .pend_count(pend_count),
    .out_change(out_change), .overflow(overflow),
    .t0(tim_q[0]), .t1(tim_q[1])
);

// File: tb/test_pend_event_filter.sv
module test_pend_event_filter;
    localparam int DEPTH = 4;
    localparam int TW    = 32;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prop_valid = 1'b0;
    logic [TW-1:0] prop_time = '0;
    logic [1:0]    prop_val = '0;
    logic [TW-1:0] inertial_dly = '0;
    logic          pop_req = 1'b0;
    logic [TW-1:0] cur_time = '0;
    logic          prop_accept, prop_discard, head_valid, out_change, overflow;
    logic [TW-1:0] head_time;
    logic [1:0]    head_val, out_val;
    logic [CW-1:0] pend_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    pend_event_filter #(.DEPTH(DEPTH), .TW(TW)) i_pend_event_filter (
        .clk(clk), .rst_n(rst_n), .prop_valid(prop_valid), .prop_time(prop_time),
        .prop_val(prop_val), .inertial_dly(inertial_dly), .pop_req(pop_req),
        .cur_time(cur_time), .prop_accept(prop_accept), .prop_discard(prop_discard),
        .head_valid(head_valid), .head_time(head_time), .head_val(head_val),
        .pend_count(pend_count), .out_val(out_val), .out_change(out_change),
        .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input longint act, input longint exp);
        chk(act == exp, req, act, exp);
    endtask

    // Monitor: compare each status pulse with the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && (prop_accept || prop_discard)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected status", longint'(prop_accept), -1);
            end else begin
                bit e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk((prop_accept == e) && (prop_discard == !e), t,
                    longint'(prop_accept), longint'(e));
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        prop_valid = 1'b0;
        pop_req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Driver: one cycle with optional propose and optional pop
    task automatic step(input bit dp, input int t, input logic [1:0] v,
                        input bit exp_acc, input string tag,
                        input bit dq, input int ct);
        if (dp) begin
            exp_q.push_back(exp_acc);
            tag_q.push_back(tag);
        end
        prop_valid = dp;
        prop_time  = TW'(t);
        prop_val   = v;
        pop_req    = dq;
        cur_time   = TW'(ct);
        @(negedge clk);
        prop_valid = 1'b0;
        pop_req    = 1'b0;
    endtask

    task automatic propose(input int t, input logic [1:0] v, input bit exp_acc, input string tag);
        step(1'b1, t, v, exp_acc, tag, 1'b0, 0);
    endtask

    task automatic pop(input int ct);
        step(1'b0, 0, 2'b00, 1'b0, "", 1'b1, ct);
    endtask

    initial begin
        #(4 * 20000);
        chk(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk_eq("R1 count", pend_count, 0);
        chk_eq("R1 head_valid", head_valid, 0);
        chk_eq("R1 out_val", out_val, 2);
        chk_eq("R1 overflow", overflow, 0);

        // R2 empty list
        propose(10, 2'b10, 1'b0, "R2 same as committed");
        chk_eq("R2 count after discard", pend_count, 0);
        propose(10, 2'b01, 1'b1, "R2 differs");
        chk_eq("R2 count", pend_count, 1);
        chk_eq("R10 head time", head_time, 10);

        // R3 after last
        propose(20, 2'b01, 1'b0, "R3 same as last");
        chk_eq("R3 count", pend_count, 1);
        propose(30, 2'b00, 1'b1, "R3 differs");
        chk_eq("R3 count2", pend_count, 2);

        // R4 before first: [1@10,0@30]
        propose(5, 2'b00, 1'b1, "R4 insert front");
        chk_eq("R4 count", pend_count, 3);
        chk_eq("R4 head time", head_time, 5);
        propose(2, 2'b00, 1'b1, "R4 replace front");
        chk_eq("R4 count replace", pend_count, 3);
        chk_eq("R4 head time replace", head_time, 2);

        // R5 between: [0@2,1@10,0@30]
        propose(20, 2'b01, 1'b0, "R5 same as preceding");
        chk_eq("R5 count discard", pend_count, 3);
        propose(15, 2'b00, 1'b1, "R5 replace follower");
        chk_eq("R5 count replace", pend_count, 3);
        propose(12, 2'b10, 1'b1, "R5 plain insert");
        chk_eq("R5 count insert", pend_count, 4);

        // R7 overflow: [0@2,1@10,X@12,0@15]
        propose(100, 2'b01, 1'b0, "R7 overflow discard");
        chk_eq("R7 count", pend_count, 4);
        chk_eq("R7 flag", overflow, 1);

        // R8 pop
        pop(1);
        chk_eq("R8 mismatched pop count", pend_count, 4);
        chk_eq("R8 mismatched pop strobe", out_change, 0);
        pop(2);
        chk_eq("R8 pop count", pend_count, 3);
        chk_eq("R8 out_val", out_val, 0);
        chk_eq("R8 strobe", out_change, 1);
        chk_eq("R8 new head", head_time, 10);
        @(negedge clk);
        chk_eq("R8 strobe one cycle", out_change, 0);
        chk_eq("R7 sticky", overflow, 1);

        // R6 inertial
        do_reset();
        chk_eq("R1 overflow cleared", overflow, 0);
        inertial_dly = 3;
        propose(1, 2'b00, 1'b1, "R6 setup 0@1");
        propose(5, 2'b01, 1'b1, "R6 setup 1@5");
        propose(6, 2'b00, 1'b0, "R6 short pulse");
        chk_eq("R6 last removed", pend_count, 1);
        chk_eq("R6 head", head_time, 1);
        propose(5, 2'b01, 1'b1, "R6 re-add 1@5");
        propose(9, 2'b00, 1'b1, "R6 wide pulse kept");
        chk_eq("R6 count", pend_count, 3);
        propose(10, 2'b10, 1'b1, "R6 no return to prior");
        chk_eq("R6 count2", pend_count, 4);
        inertial_dly = 0;

        // R9 same-cycle pop first
        do_reset();
        propose(10, 2'b01, 1'b1, "R9 setup");
        step(1'b1, 5, 2'b01, 1'b0, "R9 judged after pop", 1'b1, 10);
        chk_eq("R9 count", pend_count, 0);
        chk_eq("R9 out_val", out_val, 1);
        chk_eq("R9 strobe", out_change, 1);

        repeat (2) @(negedge clk);
        chk_eq("R10 all answered", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule